// File: doc/BRIEF.md
# Processor Flag Register with Single-Bit Set/Clear Decode

This block holds an eight-bit processor flag register. From most significant to least significant bit, it holds:

- interrupt enable
- transfer bit
- half carry
- sign
- overflow
- negative
- zero
- carry

The block decodes two instruction forms. One forces a single chosen flag to 1, and the other forces it to 0. A three-bit selector field in the instruction word picks the flag, and one opcode bit picks between set and clear. Every named "set carry", "clear interrupt" style instruction is one of these two forms with a fixed selector.

The same register also takes flag results from an arithmetic unit through a parallel port. Each bit of that port has its own write enable. When an instruction and an arithmetic update arrive in the same cycle, the instruction decides its selected bit. The arithmetic update writes every other enabled bit. The register contents go out in full, and the interrupt-enable bit also has its own output for an interrupt controller.

Top module: `flag_status_reg`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it rises with no update presented, `flags_q` reads 8'h00 and `irq_en` reads 0.
- R2: A valid word matching `1001_0100_0sss_1000` (bits 15..8 = 8'h94, bit 7 = 0, bits 3..0 = 4'h8) makes bit `sss` of `flags_q` read 1 after the next rising clock edge.
- R3: A valid word matching `1001_0100_1sss_1000` (bit 7 = 1) makes bit `sss` of `flags_q` read 0 after the next rising clock edge.
- R4: A set or clear instruction changes no bit other than the one selected by `sss`. Setting an already-set bit leaves the register unchanged.
- R5: An instruction word has no effect when `instr_vld` is low, when bits 15..8 differ from 8'h94, or when bits 3..0 differ from 4'h8.
- R6: With no recognised instruction, each bit whose `alu_we` bit is 1 takes the matching `alu_flags` bit at the next edge, and each bit whose `alu_we` bit is 0 holds its value.
- R7: When a recognised instruction and an enabled ALU write target the same bit in one cycle, the instruction's value is stored there. ALU writes to all other enabled bits still apply.
- R8: `irq_en` always equals bit 7 of `flags_q`. Setting selector 7 enables interrupts, and clearing it disables them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_vld | input | 1 | Qualifies `instr_word` for this cycle |
| instr_word | input | 16 | Instruction word to decode |
| alu_we | input | 8 | Per-bit write enable for the ALU flag port |
| alu_flags | input | 8 | Flag values from the ALU |
| flags_q | output | 8 | Register contents, bit 7 = interrupt enable, bit 0 = carry |
| irq_en | output | 1 | Interrupt-enable bit for an interrupt controller |

## Verification
The bench builds the block with its defaults: eight flags, a three-bit selector, and a sixteen-bit word with the 8'h94 prefix and 4'h8 suffix. These defaults let every selector value, both polarities and the full byte-wide ALU enable mask be reached. A single-bit change in the prefix or the suffix is enough to test rejection. With the same defaults, the instruction and the ALU can be made to collide on any one bit while the ALU also writes all seven others.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;

    localparam int unsigned NFLAG    = 8;
    localparam int unsigned SEL_W    = $clog2(NFLAG);
    localparam int unsigned INSTR_W  = 16;

    // Bit positions that other logic depends on
    localparam int unsigned IDX_IE   = 7;
    localparam int unsigned IDX_CY   = 0;

    typedef logic [NFLAG-1:0] flag_vec_t;

    typedef struct packed {
        logic             hit;
        logic             clr;
        logic [SEL_W-1:0] sel;
    } bitop_t;

    typedef struct packed {
        flag_vec_t flags;
    } flagreg_state_t;

endpackage

// File: rtl/flagreg_decode.sv
module flagreg_decode
    import flagreg_pkg::*;
#(
    parameter int unsigned WORD_W   = INSTR_W,
    parameter int unsigned PRE_W    = 8,
    parameter logic [PRE_W-1:0] PRE_VAL = 8'h94,
    parameter int unsigned SUF_W    = 4,
    parameter logic [SUF_W-1:0] SUF_VAL = 4'h8
) (
    input  logic              vld,
    input  logic [WORD_W-1:0] word,
    output bitop_t            op
);
    localparam int unsigned POL_BIT = SUF_W + SEL_W;
    localparam int unsigned PRE_LSB = WORD_W - PRE_W;

    logic pre_ok_d;
    logic suf_ok_d;

    always_comb begin
        pre_ok_d = (word[WORD_W-1:PRE_LSB] == PRE_VAL);
        suf_ok_d = (word[SUF_W-1:0] == SUF_VAL);
        op.hit   = vld && pre_ok_d && suf_ok_d;
        op.clr   = word[POL_BIT];
        op.sel   = word[SUF_W +: SEL_W];
    end

endmodule

// File: rtl/flagreg_merge.sv
module flagreg_merge
    import flagreg_pkg::*;
(
    input  flag_vec_t cur,
    input  bitop_t    op,
    input  flag_vec_t alu_we,
    input  flag_vec_t alu_val,
    output flag_vec_t nxt
);
    for (genvar g = 0; g < NFLAG; g++) begin : g_bit
        logic pick_d;
        always_comb begin
            pick_d = op.hit && (op.sel == SEL_W'(g));
            if (pick_d)
                nxt[g] = ~op.clr;
            else if (alu_we[g])
                nxt[g] = alu_val[g];
            else
                nxt[g] = cur[g];
        end
    end

endmodule

// File: rtl/flag_status_reg.sv
module flag_status_reg
    import flagreg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_vld,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic [NFLAG-1:0]   alu_we,
    input  logic [NFLAG-1:0]   alu_flags,
    output logic [NFLAG-1:0]   flags_q,
    output logic               irq_en
);
    bitop_t         op;
    flag_vec_t      merged;
    flagreg_state_t st_d;
    flagreg_state_t st_q;

    flagreg_decode i_dec (
        .vld  (instr_vld),
        .word (instr_word),
        .op   (op)
    );

    flagreg_merge i_mrg (
        .cur     (st_q.flags),
        .op      (op),
        .alu_we  (alu_we),
        .alu_val (alu_flags),
        .nxt     (merged)
    );

    always_comb begin
        st_d       = st_q;
        st_d.flags = merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign flags_q = st_q.flags;
    assign irq_en  = st_q.flags[IDX_IE];

    // R2: set instruction leaves its bit at 1
    a_r2_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (op.hit && !op.clr) |=> flags_q[$past(op.sel)] == 1'b1);

    // R3: clear instruction leaves its bit at 0
    a_r3_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (op.hit && op.clr) |=> flags_q[$past(op.sel)] == 1'b0);

    // R4: without ALU writes at most one bit moves
    a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (op.hit && alu_we == '0) |=> $countones(flags_q ^ $past(flags_q)) <= 1);

    // R5: nothing recognised and no ALU write keeps the register
    a_r5_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!op.hit && alu_we == '0) |=> $stable(flags_q));

    // R6: enabled ALU bits land when no instruction competes
    a_r6_alu_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!op.hit) |=> ((flags_q & $past(alu_we)) == ($past(alu_flags) & $past(alu_we))));

    // R8: interrupt enable output tracks bit 7 over time
    a_r8_irq_track: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[IDX_IE]) |-> $rose(irq_en));

endmodule

// File: tb/test_flag_status_reg.sv
module test_flag_status_reg;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_vld;
    logic [15:0] instr_word;
    logic [7:0]  alu_we;
    logic [7:0]  alu_flags;
    logic [7:0]  flags_q;
    logic        irq_en;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    flag_status_reg i_flag_status_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_vld  (instr_vld),
        .instr_word (instr_word),
        .alu_we     (alu_we),
        .alu_flags  (alu_flags),
        .flags_q    (flags_q),
        .irq_en     (irq_en)
    );

    // {req code, vld, word, we, alu, expected flags}
    localparam int NV = 15;
    localparam logic [44:0] VEC [NV] = '{
        {4'd2, 1'b1, 16'h9478, 8'h00, 8'h00, 8'h80},
        {4'd2, 1'b1, 16'h9408, 8'h00, 8'h00, 8'h81},
        {4'd2, 1'b1, 16'h9418, 8'h00, 8'h00, 8'h83},
        {4'd3, 1'b1, 16'h94F8, 8'h00, 8'h00, 8'h03},
        {4'd3, 1'b1, 16'h9488, 8'h00, 8'h00, 8'h02},
        {4'd5, 1'b0, 16'h9438, 8'h00, 8'h00, 8'h02},
        {4'd5, 1'b1, 16'h9439, 8'h00, 8'h00, 8'h02},
        {4'd5, 1'b1, 16'h9538, 8'h00, 8'h00, 8'h02},
        {4'd6, 1'b0, 16'h0000, 8'hF0, 8'hA5, 8'hA2},
        {4'd6, 1'b0, 16'h0000, 8'h0F, 8'h0C, 8'hAC},
        {4'd7, 1'b1, 16'h94D8, 8'hFF, 8'hFF, 8'hDF},
        {4'd7, 1'b1, 16'h9438, 8'h08, 8'h00, 8'hDF},
        {4'd4, 1'b1, 16'h9428, 8'h00, 8'h00, 8'hDF},
        {4'd3, 1'b1, 16'h94E8, 8'h00, 8'h00, 8'h9F},
        {4'd6, 1'b0, 16'h94C8, 8'h00, 8'hFF, 8'h9F}
    };

    function automatic string tag(input logic [3:0] c);
        case (c)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, sample 2 ns after the following rising edge
    task automatic step(input logic v, input logic [15:0] w,
                        input logic [7:0] we, input logic [7:0] fl);
        @(negedge clk);
        instr_vld = v; instr_word = w; alu_we = we; alu_flags = fl;
        @(posedge clk);
        #2;
        instr_vld = 1'b0; instr_word = '0; alu_we = '0; alu_flags = '0;
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; instr_vld = 1'b0; instr_word = '0; alu_we = '0; alu_flags = '0;
        repeat (3) @(posedge clk);
        #2;
        check8("R1", flags_q, 8'h00);
        check8("R1", {7'd0, irq_en}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 16'h0000, 8'h00, 8'h00);
        check8("R1", flags_q, 8'h00);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][40], VEC[i][39:24], VEC[i][23:16], VEC[i][15:8]);
            check8(tag(VEC[i][44:41]), flags_q, VEC[i][7:0]);
            check8("R8", {7'd0, irq_en}, {7'd0, VEC[i][7]});
        end

        // walk each selector from a cleared and a full register
        for (int s = 0; s < 8; s++) begin
            rst_n = 1'b0;
            step(1'b0, 16'h0000, 8'h00, 8'h00);
            rst_n = 1'b1;
            step(1'b1, 16'h9408 | (16'(s) << 4), 8'h00, 8'h00);
            check8("R2", flags_q, 8'(1 << s));
            step(1'b0, 16'h0000, 8'hFF, 8'hFF);
            step(1'b1, 16'h9488 | (16'(s) << 4), 8'h00, 8'h00);
            check8("R4", flags_q, ~8'(1 << s));
        end

        // interrupt enable via selector 7
        step(1'b1, 16'h9478, 8'h00, 8'h00);
        check8("R8", {7'd0, irq_en}, 8'h01);
        step(1'b1, 16'h94F8, 8'h00, 8'h00);
        check8("R8", {7'd0, irq_en}, 8'h00);

        // reset in mid-operation
        step(1'b0, 16'h0000, 8'hFF, 8'hFF);
        rst_n = 1'b0;
        step(1'b1, 16'h9478, 8'hFF, 8'hFF);
        check8("R1", flags_q, 8'h00);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule